// File: doc/BRIEF.md
# Microstepping Step/Direction Indexer

This block turns a step pulse and a direction level into current commands for the two windings of a two-phase stepper motor. It keeps the rotor's electrical angle as an index into a 128-position circle, about 2.8 degrees per position. On each rising edge of the step input it moves that index by an amount set by the selected step resolution. For the current index it outputs one signed current level per winding in units of 5% of full scale. Winding A follows the cosine of the angle and winding B the sine. Each winding also has a flag that tells a downstream chopper whether that winding's current magnitude has just grown, so the chopper can use slow decay while the current rises.

The resolution is selected by a 3-bit mode code, decoded outside the block from the board-level mode pins. It is sampled on each step edge and may change while the motor turns. When the current index is not a valid point for the new resolution, the indexer moves to the nearest valid point in the step direction. Full-step operation uses only the four diagonal points, where both windings carry the same reduced amplitude.

A sleep request forces the 45-degree home point and ignores steps. The drive-off input removes only the output enable, and the index keeps tracking. The step input is asynchronous and is synchronized inside the block. The direction and mode inputs are expected to be stable around each step edge.

Top module: `microstep_indexer`

## Requirements
- R1: After reset, and one clock after `sleep_req` is sampled high, the index is the 45-degree home point (0-based position 16): `cur_a` = +14, `cur_b` = +14, both rise flags 0 and `out_en` 0.
- R2: For position p (0-based, 0..127), `cur_a` = round(20·cos(p·360/128 deg)) and `cur_b` = round(20·sin(p·360/128 deg)). Both are two's-complement 6-bit values in units of 5%, within -20..+20.
- R3: The mode code sets the stride per step edge: 0 = full step (32), 1 = half (16), 2 = quarter (8), 3 = eighth (4), 4 = sixteenth (2), and 5, 6 or 7 = thirty-second (1).
- R4: In full-step mode (code 0) the index only lands on positions 16, 48, 80 and 112, where both windings are at magnitude 14.
- R5: With `dir_in` = 1 the index increases, and with `dir_in` = 0 it decreases, modulo 128 (127 up goes to 0, and 0 down goes to 127).
- R6: A valid point for stride s is a position p with p mod s = 0. In full-step mode it is a position with (p-16) mod 32 = 0. A step edge moves the index by single positions in the step direction until it reaches the first valid point for the current mode. From a valid point this is exactly one stride. After a mode change it is the nearest valid point ahead.
- R7: A rising edge of `step_in` passes through a two-flop synchronizer. The outputs change on the third rising clock edge after `step_in` rises, never earlier. A step held high causes exactly one advance.
- R8: `drive_off` = 1 clears `out_en` one clock later while steps still move the index. `out_en` is 1 one clock after `drive_off` and `sleep_req` are both 0.
- R9: On each advance, a winding's rise flag becomes 1 when its new magnitude is strictly larger than its previous magnitude, and 0 otherwise. The flags hold between advances.
- R10: While `sleep_req` is high, step edges are ignored and the index stays at home.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Synchronous sleep: home the index, ignore steps, disable outputs |
| step_in | input | 1 | Asynchronous step pulse, advances on the rising edge |
| dir_in | input | 1 | 1 = increasing index, 0 = decreasing |
| mode_code | input | 3 | Decoded step resolution code (see R3) |
| drive_off | input | 1 | 1 = drop output enable while tracking continues |
| cur_a | output | 6 | Signed winding A current level, 5% units |
| cur_b | output | 6 | Signed winding B current level, 5% units |
| rise_a | output | 1 | Winding A magnitude rose on the last advance |
| rise_b | output | 1 | Winding B magnitude rose on the last advance |
| out_en | output | 1 | Output stage enable |

## Verification
The bench builds the block with its default synchronizer depth of two stages. This makes the three-clock latency from a step edge to the new outputs exact, and the bench checks that latency cycle by cycle. It computes the expected levels from floating-point sine and cosine rounded to 5% steps, and finds the next position by walking one position at a time to the next valid point. That makes the full 128-point circle, both wraps, every mode code including the unused ones, and mode changes from misaligned positions all reachable in a few thousand cycles.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

    localparam int POS_W    = 7;                 // 128 electrical positions
    localparam int QTR      = 1 << (POS_W - 2);  // positions per quadrant
    localparam int MAG_W    = 5;                 // magnitude 0..20
    localparam int CUR_W    = MAG_W + 1;         // signed level
    localparam int NWIND    = 2;                 // windings A and B
    localparam logic [POS_W-1:0] HOME_POS = POS_W'(QTR / 2);  // 45 degrees
    localparam logic [POS_W-1:0] FULL_OFS = POS_W'(QTR / 2);  // full-step grid offset

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [NWIND-1:0] rise;
        logic             out_en;
    } idx_state_t;

    // log2 of the stride for each mode code; codes above 5 use the finest grid
    function automatic logic [2:0] stride_log2(input logic [2:0] mode);
        case (mode)
            3'd0:    return 3'd5;
            3'd1:    return 3'd4;
            3'd2:    return 3'd3;
            3'd3:    return 3'd2;
            3'd4:    return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

    // Quarter-wave magnitude: round(20*sin(j*90/32 deg)) for j = 0..32
    function automatic logic [MAG_W-1:0] qtr_level(input logic [5:0] j);
        case (j)
            6'd0:  return 5'd0;
            6'd1:  return 5'd1;
            6'd2:  return 5'd2;
            6'd3:  return 5'd3;
            6'd4:  return 5'd4;
            6'd5:  return 5'd5;
            6'd6:  return 5'd6;
            6'd7:  return 5'd7;
            6'd8:  return 5'd8;
            6'd9:  return 5'd9;
            6'd10: return 5'd9;
            6'd11: return 5'd10;
            6'd12: return 5'd11;
            6'd13: return 5'd12;
            6'd14: return 5'd13;
            6'd15: return 5'd13;
            6'd16: return 5'd14;
            6'd17: return 5'd15;
            6'd18: return 5'd15;
            6'd19: return 5'd16;
            6'd20: return 5'd17;
            6'd21: return 5'd17;
            6'd22: return 5'd18;
            6'd23: return 5'd18;
            6'd24: return 5'd18;
            6'd25: return 5'd19;
            6'd26: return 5'd19;
            6'd27: return 5'd19;
            default: return 5'd20;   // 28..32 saturate at full scale
        endcase
    endfunction

endpackage

// File: rtl/mstep_sync_edge.sv
module mstep_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    // chain_q[STAGES-1:0] is the synchronizer, chain_q[STAGES] the history flop
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/mstep_next_pos.sv
module mstep_next_pos
    import mstep_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  logic             dir_up,
    input  logic [2:0]       mode,
    output logic [POS_W-1:0] nxt
);
    logic [2:0]       shf;
    logic [POS_W-1:0] ofs, stride, mask, rel, base, moved;

    always_comb begin
        shf    = stride_log2(mode);
        ofs    = (mode == 3'd0) ? FULL_OFS : '0;
        stride = POS_W'(1) << shf;
        mask   = stride - POS_W'(1);
        rel    = pos - ofs;          // position relative to the active grid
        base   = rel & ~mask;        // grid point at or below
        if (dir_up)
            moved = base + stride;   // first grid point strictly above
        else if ((rel & mask) == '0)
            moved = rel - stride;    // on grid: one full stride down
        else
            moved = base;            // off grid: nearest point below
        nxt = moved + ofs;
    end

endmodule

// File: rtl/mstep_wave.sv
module mstep_wave
    import mstep_pkg::*;
#(
    parameter int PHASE = 0          // 0 = sine, QTR = cosine
) (
    input  logic [POS_W-1:0]        pos,
    output logic signed [CUR_W-1:0] level,
    output logic [MAG_W-1:0]        mag
);
    localparam logic [POS_W-1:0] SHIFT = POS_W'(PHASE);

    logic [POS_W-1:0] p;
    logic [1:0]       quad;
    logic [5:0]       rem, fold;

    always_comb begin
        p     = pos + SHIFT;
        quad  = p[POS_W-1 -: 2];
        rem   = {1'b0, p[POS_W-3:0]};
        fold  = quad[0] ? (6'(QTR) - rem) : rem;   // mirror odd quadrants
        mag   = qtr_level(fold);
        level = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

endmodule

// File: rtl/microstep_indexer.sv
module microstep_indexer
    import mstep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep_req,
    input  logic                    step_in,
    input  logic                    dir_in,
    input  logic [2:0]              mode_code,
    input  logic                    drive_off,
    output logic signed [CUR_W-1:0] cur_a,
    output logic signed [CUR_W-1:0] cur_b,
    output logic                    rise_a,
    output logic                    rise_b,
    output logic                    out_en
);
    idx_state_t state_d, state_q;

    logic                    step_rise;
    logic [POS_W-1:0]        nxt_pos;
    logic [POS_W-1:0]        pos_now;
    logic signed [CUR_W-1:0] lvl_now [NWIND];
    logic [MAG_W-1:0]        mag_now [NWIND];
    logic signed [CUR_W-1:0] lvl_nxt [NWIND];
    logic [MAG_W-1:0]        mag_nxt [NWIND];

    mstep_sync_edge #(.STAGES(SYNC_STAGES)) u_step_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (step_in),
        .rise (step_rise)
    );

    mstep_next_pos u_next (
        .pos   (state_q.pos),
        .dir_up(dir_in),
        .mode  (mode_code),
        .nxt   (nxt_pos)
    );

    // winding 0 = A (cosine), winding 1 = B (sine)
    for (genvar w = 0; w < NWIND; w++) begin : g_wind
        localparam int PH = (w == 0) ? QTR : 0;

        mstep_wave #(.PHASE(PH)) u_now (
            .pos  (state_q.pos),
            .level(lvl_now[w]),
            .mag  (mag_now[w])
        );

        mstep_wave #(.PHASE(PH)) u_nxt (
            .pos  (nxt_pos),
            .level(lvl_nxt[w]),
            .mag  (mag_nxt[w])
        );
    end

    always_comb begin
        state_d        = state_q;
        state_d.out_en = !sleep_req && !drive_off;
        if (sleep_req) begin
            state_d.pos  = HOME_POS;
            state_d.rise = '0;
        end else if (step_rise) begin
            state_d.pos = nxt_pos;
            for (int w = 0; w < NWIND; w++) begin
                state_d.rise[w] = (mag_nxt[w] > mag_now[w]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.pos    <= HOME_POS;
            state_q.rise   <= '0;
            state_q.out_en <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pos_now = state_q.pos;
    assign cur_a   = lvl_now[0];
    assign cur_b   = lvl_now[1];
    assign rise_a  = state_q.rise[0];
    assign rise_b  = state_q.rise[1];
    assign out_en  = state_q.out_en;

endmodule

// File: rtl/mstep_checker.sv
module mstep_checker (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_req,
    input logic              dir_in,
    input logic [2:0]        mode_code,
    input logic              drive_off,
    input logic              step_rise,
    input logic [6:0]        pos,
    input logic signed [5:0] cur_a,
    input logic signed [5:0] cur_b,
    input logic              rise_a,
    input logic              rise_b,
    input logic              out_en
);
    logic [5:0] mag_a, mag_b;
    assign mag_a = cur_a[5] ? 6'(-cur_a) : 6'(cur_a);
    assign mag_b = cur_b[5] ? 6'(-cur_b) : 6'(cur_b);

    a_r1_sleep_home: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> (cur_a == 6'sd14 && cur_b == 6'sd14 && !rise_a && !rise_b && !out_en));

    a_r2_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        (mag_a <= 6'd20 && mag_b <= 6'd20));

    a_r3_fine_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rise && !sleep_req && mode_code == 3'd5)
        |=> (7'(pos - $past(pos)) == ($past(dir_in) ? 7'd1 : 7'd127)));

    a_r4_full_grid: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rise && !sleep_req && mode_code == 3'd0) |=> (pos[4:0] == 5'd16));

    a_r7_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_rise && !sleep_req) |=> $stable(pos));

    a_r8_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
        drive_off |=> !out_en);

    a_r8_enable_back: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_off && !sleep_req) |=> out_en);

    a_r9_rise_a: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rise && !sleep_req) |=> (rise_a == (mag_a > $past(mag_a))));

    a_r9_rise_b: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rise && !sleep_req) |=> (rise_b == (mag_b > $past(mag_b))));

    a_r10_sleep_ignores_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && step_rise) |=> (pos == 7'd16));

endmodule

bind microstep_indexer mstep_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_req(sleep_req),
    .dir_in   (dir_in),
    .mode_code(mode_code),
    .drive_off(drive_off),
    .step_rise(step_rise),
    .pos      (pos_now),
    .cur_a    (cur_a),
    .cur_b    (cur_b),
    .rise_a   (rise_a),
    .rise_b   (rise_b),
    .out_en   (out_en)
);

// File: tb/microstep_indexer_test.sv
`timescale 1ns/1ps
module microstep_indexer_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sleep_req = 1'b0;
    logic              step_in = 1'b0;
    logic              dir_in = 1'b1;
    logic [2:0]        mode_code = 3'd5;
    logic              drive_off = 1'b0;
    logic signed [5:0] cur_a, cur_b;
    logic              rise_a, rise_b, out_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int  m_pos = 16;
    bit  m_rise_a = 1'b0, m_rise_b = 1'b0;

    always #2.5 clk = ~clk;

    microstep_indexer uut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .step_in(step_in),
        .dir_in(dir_in), .mode_code(mode_code), .drive_off(drive_off),
        .cur_a(cur_a), .cur_b(cur_b), .rise_a(rise_a), .rise_b(rise_b), .out_en(out_en)
    );

    function automatic int exp_lvl(int p, bit is_cos);
        real ang, v;
        ang = real'((p + (is_cos ? 32 : 0)) % 128) * 2.0 * 3.14159265358979 / 128.0;
        v   = 20.0 * $sin(ang);
        if (v >= 0.0) return int'($floor(v + 0.5));
        else          return -int'($floor(-v + 0.5));
    endfunction

    function automatic int iabs(int x);
        return (x < 0) ? -x : x;
    endfunction

    function automatic bit on_grid(int p, int mode);
        int stride, ofs;
        case (mode)
            0: begin stride = 32; ofs = 16; end
            1: begin stride = 16; ofs = 0; end
            2: begin stride = 8;  ofs = 0; end
            3: begin stride = 4;  ofs = 0; end
            4: begin stride = 2;  ofs = 0; end
            default: begin stride = 1; ofs = 0; end
        endcase
        return (((p - ofs + 128) % stride) == 0);
    endfunction

    task automatic model_advance(bit up, int mode);
        int np = m_pos;
        do np = (np + (up ? 1 : 127)) % 128; while (!on_grid(np, mode));
        m_rise_a = iabs(exp_lvl(np, 1)) > iabs(exp_lvl(m_pos, 1));
        m_rise_b = iabs(exp_lvl(np, 0)) > iabs(exp_lvl(m_pos, 0));
        m_pos = np;
    endtask

    task automatic chk(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " cur_a"}, int'(cur_a), exp_lvl(m_pos, 1));
        chk({tag, " cur_b"}, int'(cur_b), exp_lvl(m_pos, 0));
        chk({tag, " rise_a R9"}, int'(rise_a), int'(m_rise_a));
        chk({tag, " rise_b R9"}, int'(rise_b), int'(m_rise_b));
        chk({tag, " out_en R8"}, int'(out_en), int'(!sleep_req && !drive_off));
    endtask

    task automatic pulse_step(bit up, int mode, string tag);
        @(negedge clk);
        dir_in = up;
        mode_code = 3'(mode);
        step_in = 1'b1;
        repeat (4) @(negedge clk);
        step_in = 1'b0;
        repeat (4) @(negedge clk);
        if (!sleep_req) model_advance(up, mode);
        check_all(tag);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state (out_en registered one clock after reset release)
        chk("R1 reset cur_a", int'(cur_a), 14);
        chk("R1 reset cur_b", int'(cur_b), 14);
        chk("R1 reset rise_a", int'(rise_a), 0);
        @(negedge clk);
        check_all("R1 reset");

        // R7 latency: change visible on third clock edge after step rises
        dir_in = 1'b1; mode_code = 3'd5; step_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 no change after two edges cur_b", int'(cur_b), exp_lvl(16, 0));
        @(negedge clk);
        model_advance(1'b1, 5);
        chk("R7 change on third edge cur_b", int'(cur_b), exp_lvl(m_pos, 0));
        repeat (6) @(negedge clk);
        check_all("R7 held step single advance");
        step_in = 1'b0;
        repeat (4) @(negedge clk);
        check_all("R7 after release");

        // R6 mode change from misaligned position 17: full step up -> 48
        pulse_step(1'b1, 0, "R6 R4 full from misaligned");
        chk("R4 grid position", m_pos, 48);
        // R4 R5 full step walk upward with wrap through 112 -> 16
        for (int i = 0; i < 4; i++) pulse_step(1'b1, 0, "R4 R5 full up");
        chk("R5 full wrap back", m_pos, 48);
        // R6 misaligned then quarter down / up
        pulse_step(1'b0, 5, "R3 fine down");
        pulse_step(1'b0, 2, "R6 quarter down misaligned");
        chk("R6 quarter down target", m_pos, 40);
        pulse_step(1'b0, 4, "R3 sixteenth");
        pulse_step(1'b1, 1, "R6 half up");
        chk("R6 half up target", m_pos, 48);

        // R10 sleep: home, steps ignored
        @(negedge clk); sleep_req = 1'b1;
        m_pos = 16; m_rise_a = 1'b0; m_rise_b = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R1 R10 sleep home");
        pulse_step(1'b1, 5, "R10 step during sleep");
        pulse_step(1'b0, 0, "R10 step during sleep");
        @(negedge clk); sleep_req = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R10 wake");

        // R5 wrap downward through 0 -> 127
        for (int i = 0; i < 17; i++) pulse_step(1'b0, 5, "R5 fine down");
        chk("R5 wrap below zero", m_pos, 127);
        pulse_step(1'b1, 7, "R3 code 7 fine up");
        chk("R5 wrap above top", m_pos, 0);

        // R8 drive_off keeps tracking
        @(negedge clk); drive_off = 1'b1;
        @(negedge clk);
        check_all("R8 drive off");
        pulse_step(1'b1, 3, "R8 tracking while off");
        pulse_step(1'b1, 6, "R3 code 6 while off");
        @(negedge clk); drive_off = 1'b0;
        @(negedge clk);
        check_all("R8 enable back");

        // random mix
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 16) == 0) begin
                @(negedge clk); drive_off = $urandom % 2;
            end
            pulse_step(1'($urandom % 2), int'($urandom % 8), "R2 R3 R6 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule